// File: doc/BRIEF.md
# RC4 Brute-Force Key Search Core

This core recovers the plaintext of a 32-byte RC4 ciphertext under a 24-bit key. It keeps the 256-entry permutation table in one internal single-port memory. Each key attempt runs three phases in order. The first loads the table with the identity. The second mixes the key into the table. The third produces the keystream, XORs it with the stored ciphertext and writes the result into a 32-byte plaintext buffer. The scheduler starts a phase only after the previous one has ended.

Software first loads the ciphertext one byte at a time. It then pulses start with a first key and a last key. In single-key mode the core decrypts all 32 bytes under the first key. It then reports whether the result looks like text. In search mode the core tests keys in ascending order, starting at the first key. A candidate is dropped at the first byte that is not a lowercase letter or a space, and the next key begins at once. The search halts on the first key whose plaintext passes the test, or after the last key has failed. The key under test is visible on an output throughout.

Top module: `rc4_key_search`

## Requirements
- R1: After reset, done and found are low and cur_key is zero.
- R2: The 24-bit key is used as three bytes in this order: byte 0 = bits [23:16], byte 1 = bits [15:8], byte 2 = bits [7:0]. Byte (i mod 3) is used at step i of key mixing.
- R3: With search_en low, the core decrypts all 32 bytes under key_lo. Afterwards pt_data at address k equals ciphertext byte k XOR keystream byte k of standard RC4.
- R4: A plaintext counts as plausible when every byte is in 0x61..0x7A or equals 0x20. In single-key mode, found is set at completion exactly when the plaintext is plausible. A non-plausible byte in the last position (31) clears found.
- R5: With search_en high, the core tests keys key_lo, key_lo+1, … in order. It stops at the first plausible key with done and found high and cur_key holding that key. The plaintext buffer then holds the decryption under that key. found is never high while done is low.
- R6: If no key in key_lo..key_hi is plausible, done rises with found low and cur_key equal to key_hi. cur_key never exceeds key_hi during a run.
- R7: Ciphertext byte ct_addr is written with ct_data on each clock with ct_we high while the core is idle.
- R8: start is accepted only while idle. The next cycle the core is busy and done is low, and done stays low until the run ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (idle only) |
| search_en | input | 1 | 1: search key range, 0: decrypt key_lo only |
| key_lo | input | 24 | First key of the run |
| key_hi | input | 24 | Last key of the run (key_hi >= key_lo) |
| ct_we | input | 1 | Ciphertext byte write enable |
| ct_addr | input | 5 | Ciphertext byte index |
| ct_data | input | 8 | Ciphertext byte value |
| pt_addr | input | 5 | Plaintext buffer read index |
| pt_data | output | 8 | Plaintext byte at pt_addr |
| done | output | 1 | Run finished, held until next start |
| found | output | 1 | Plausible plaintext found |
| cur_key | output | 24 | Key under test, final key after the run |

## Verification
The hardest case to reach from the ports is a candidate that passes every check up to the last byte and then fails there. Random keys almost always fail on the first few bytes. So the bench builds its own RC4 model, picks a plaintext whose final byte alone is an uppercase letter, and encrypts it under a key placed in the middle of the search range. The search must then reject that key at byte 31 and run to the end of the range. Key ranges that carry across a byte boundary of the key exercise the key-increment and key-byte ordering together.

// File: rtl/rc4_key_search.sv
module rc4_key_search #(
  parameter int MSG_LEN = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        search_en,
  input  logic [23:0] key_lo,
  input  logic [23:0] key_hi,
  input  logic        ct_we,
  input  logic [4:0]  ct_addr,
  input  logic [7:0]  ct_data,
  input  logic [4:0]  pt_addr,
  output logic [7:0]  pt_data,
  output logic        done,
  output logic        found,
  output logic [23:0] cur_key
);
  localparam int MW = $clog2(MSG_LEN);
  localparam logic [MW-1:0] K_LAST = MW'(MSG_LEN - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_INIT, S_KRI, S_KRJ, S_KWI, S_KWJ,
    S_GRI, S_GRJ, S_GWI, S_GWJ, S_GRF, S_GOUT
  } st_t;

  st_t          st;
  logic [7:0]   s_mem [256];
  logic [7:0]   ct_mem [MSG_LEN];
  logic [7:0]   pt_mem [MSG_LEN];
  logic [7:0]   i, j, si, sj, rd_q;
  logic [1:0]   kb;
  logic [MW-1:0] k;
  logic         ok, srch;
  logic [23:0]  key_end;

  logic [7:0]   mem_addr, mem_wd, kbyte, pbyte;
  logic         mem_we, plaus, busy;

  assign busy    = (st != S_IDLE);
  assign kbyte   = (kb == 2'd0) ? cur_key[23:16] : (kb == 2'd1) ? cur_key[15:8] : cur_key[7:0];
  assign pbyte   = rd_q ^ ct_mem[k];
  assign plaus   = (pbyte >= 8'h61 && pbyte <= 8'h7a) || pbyte == 8'h20;
  assign pt_data = pt_mem[pt_addr];

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = i;
    mem_wd   = i;
    case (st)
      S_INIT: mem_we = 1'b1;
      S_KRJ:  mem_addr = j + rd_q + kbyte;
      S_KWI:  begin mem_we = 1'b1; mem_wd = rd_q; end
      S_KWJ:  begin mem_we = 1'b1; mem_addr = j; mem_wd = si; end
      S_GRI:  mem_addr = i + 8'd1;
      S_GRJ:  mem_addr = j + rd_q;
      S_GWI:  begin mem_we = 1'b1; mem_wd = rd_q; end
      S_GWJ:  begin mem_we = 1'b1; mem_addr = j; mem_wd = si; end
      S_GRF:  mem_addr = si + sj;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) s_mem[mem_addr] <= mem_wd;
    rd_q <= s_mem[mem_addr];
    if (ct_we && !busy) ct_mem[ct_addr] <= ct_data;
    if (st == S_GOUT) pt_mem[k] <= pbyte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; done <= 1'b0; found <= 1'b0; cur_key <= '0; key_end <= '0;
      srch <= 1'b0; i <= '0; j <= '0; si <= '0; sj <= '0; kb <= '0; k <= '0; ok <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          cur_key <= key_lo; key_end <= key_hi; srch <= search_en;
          done <= 1'b0; found <= 1'b0; i <= '0; st <= S_INIT;
        end
        S_INIT: begin
          i <= i + 8'd1;
          if (i == 8'hff) begin j <= '0; kb <= '0; st <= S_KRI; end
        end
        S_KRI: st <= S_KRJ;
        S_KRJ: begin si <= rd_q; j <= j + rd_q + kbyte; st <= S_KWI; end
        S_KWI: st <= S_KWJ;
        S_KWJ: begin
          i  <= i + 8'd1;
          kb <= (kb == 2'd2) ? 2'd0 : kb + 2'd1;
          if (i == 8'hff) begin j <= '0; k <= '0; ok <= 1'b1; st <= S_GRI; end
          else st <= S_KRI;
        end
        S_GRI: begin i <= i + 8'd1; st <= S_GRJ; end
        S_GRJ: begin si <= rd_q; j <= j + rd_q; st <= S_GWI; end
        S_GWI: begin sj <= rd_q; st <= S_GWJ; end
        S_GWJ: st <= S_GRF;
        S_GRF: st <= S_GOUT;
        S_GOUT: begin
          if (srch && !plaus) begin
            if (cur_key == key_end) begin done <= 1'b1; st <= S_IDLE; end
            else begin cur_key <= cur_key + 24'd1; i <= '0; st <= S_INIT; end
          end else if (k == K_LAST) begin
            done <= 1'b1; found <= ok & plaus; st <= S_IDLE;
          end else begin
            k <= k + 1'b1; ok <= ok & plaus; st <= S_GRI;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_found_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    found |-> done);
  assert_key_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cur_key != $past(cur_key)) |-> cur_key == $past(cur_key) + 24'd1);
  assert_key_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cur_key <= key_end);
  assert_exhaust_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !found && srch) |-> cur_key == key_end);
  assert_start_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done && !found));
endmodule

// File: tb/rc4_key_search_tb_top.sv
module rc4_key_search_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, search_en = 1'b0, ct_we = 1'b0;
  logic [23:0] key_lo = '0, key_hi = '0;
  logic [4:0]  ct_addr = '0, pt_addr = '0;
  logic [7:0]  ct_data = '0;
  logic [7:0]  pt_data;
  logic        done, found;
  logic [23:0] cur_key;

  always #2 clk = ~clk;

  rc4_key_search dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .search_en(search_en),
    .key_lo(key_lo), .key_hi(key_hi), .ct_we(ct_we), .ct_addr(ct_addr),
    .ct_data(ct_data), .pt_addr(pt_addr), .pt_data(pt_data),
    .done(done), .found(found), .cur_key(cur_key)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] ks_m [32];
  logic [7:0] ct_m [32];

  localparam int NV = 7;
  localparam logic [23:0] V_TGT [NV] = '{24'h1A2B3C, 24'h000005, 24'hFF0100, 24'h123456, 24'h0ABCDE, 24'h777777, 24'h777777};
  localparam logic [23:0] V_LO  [NV] = '{24'h1A2B3C, 24'h000000, 24'hFF00FC, 24'h123450, 24'h0ABCDF, 24'h777776, 24'h777777};
  localparam logic [23:0] V_HI  [NV] = '{24'h1A2B3C, 24'h000009, 24'hFF0100, 24'h123453, 24'h0ABCDF, 24'h777778, 24'h777777};
  localparam logic        V_SR  [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam logic        V_PS  [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1};

  task automatic check(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!good) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [7:0] pt_gen(input logic sel, input int k);
    if (sel && k == 31) return 8'h51;
    if (k % 6 == 5) return 8'h20;
    return 8'h61 + 8'((k * 7) % 26);
  endfunction

  function automatic bit plaus(input logic [7:0] b);
    return (b >= 8'h61 && b <= 8'h7a) || b == 8'h20;
  endfunction

  // standard RC4, key byte 0 = bits [23:16] (R2)
  task automatic gen_ks(input logic [23:0] key);
    logic [7:0] s [256];
    logic [7:0] ii, jj, t, kbv, idx;
    for (int n = 0; n < 256; n++) s[n] = n[7:0];
    jj = '0;
    for (int n = 0; n < 256; n++) begin
      kbv = (n % 3 == 0) ? key[23:16] : (n % 3 == 1) ? key[15:8] : key[7:0];
      jj = jj + s[n] + kbv;
      t = s[n]; s[n] = s[jj]; s[jj] = t;
    end
    ii = '0; jj = '0;
    for (int m = 0; m < 32; m++) begin
      ii = ii + 8'd1;
      jj = jj + s[ii];
      t = s[ii]; s[ii] = s[jj]; s[jj] = t;
      idx = s[ii] + s[jj];
      ks_m[m] = s[idx];
    end
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    bit ok, efound, allp;
    logic [23:0] ekey;
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R1 done", 32'(done), 0);
    check(found == 1'b0, "R1 found", 32'(found), 0);
    check(cur_key == 24'h0, "R1 cur_key", 32'(cur_key), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      gen_ks(V_TGT[v]);
      for (int k = 0; k < 32; k++) ct_m[k] = pt_gen(V_PS[v], k) ^ ks_m[k];
      for (int k = 0; k < 32; k++) begin
        ct_we = 1'b1; ct_addr = 5'(k); ct_data = ct_m[k];
        @(negedge clk);
      end
      ct_we = 1'b0;

      efound = 1'b0; ekey = V_HI[v];
      if (V_SR[v]) begin
        for (logic [24:0] kk = {1'b0, V_LO[v]}; kk <= {1'b0, V_HI[v]}; kk++) begin
          gen_ks(kk[23:0]);
          allp = 1'b1;
          for (int k = 0; k < 32; k++) if (!plaus(ct_m[k] ^ ks_m[k])) allp = 1'b0;
          if (allp) begin efound = 1'b1; ekey = kk[23:0]; break; end
        end
      end else begin
        ekey = V_LO[v];
        gen_ks(ekey);
        efound = 1'b1;
        for (int k = 0; k < 32; k++) if (!plaus(ct_m[k] ^ ks_m[k])) efound = 1'b0;
      end

      key_lo = V_LO[v]; key_hi = V_HI[v]; search_en = V_SR[v]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      check(done == 1'b0, "R8 done low after start", 32'(done), 0);
      wait_done(ok);
      check(ok, "R8 run completes", 32'(ok), 1);
      check(found == efound, V_SR[v] ? "R5/R6 found" : "R4 found", 32'(found), 32'(efound));
      check(cur_key == ekey, V_SR[v] ? "R5/R6 cur_key" : "R3 cur_key", 32'(cur_key), 32'(ekey));
      if (!V_SR[v] || efound) begin
        gen_ks(ekey);
        for (int k = 0; k < 32; k++) begin
          pt_addr = 5'(k);
          #1;
          check(pt_data == (ct_m[k] ^ ks_m[k]), "R3/R7 plaintext byte", 32'(pt_data), 32'(ct_m[k] ^ ks_m[k]));
        end
      end
      repeat (3) @(negedge clk);
      check(done == 1'b1, "R8 done held", 32'(done), 1);
    end

    // start while busy is ignored (R8): result of first run unaffected
    gen_ks(24'h1A2B3C);
    for (int k = 0; k < 32; k++) begin
      ct_we = 1'b1; ct_addr = 5'(k); ct_data = pt_gen(1'b0, k) ^ ks_m[k];
      @(negedge clk);
    end
    ct_we = 1'b0;
    key_lo = 24'h1A2B3C; key_hi = 24'h1A2B3C; search_en = 1'b0; start = 1'b1;
    @(negedge clk);
    key_lo = 24'h000001; key_hi = 24'h000001;
    repeat (10) @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check(found == 1'b1, "R8 busy start ignored found", 32'(found), 1);
    check(cur_key == 24'h1A2B3C, "R8 busy start ignored key", 32'(cur_key), 32'h1A2B3C);

    // ct_we while busy is ignored (R7)
    key_lo = 24'h1A2B3C; key_hi = 24'h1A2B3C; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ct_we = 1'b1; ct_addr = 5'd0; ct_data = 8'h00;
    @(negedge clk);
    ct_we = 1'b0;
    wait_done(ok);
    pt_addr = 5'd0;
    #1;
    check(pt_data == pt_gen(1'b0, 0), "R7 busy write ignored", 32'(pt_data), 32'(pt_gen(1'b0, 0)));

    // reset returns to idle state (R1)
    rst_n = 1'b0;
    @(negedge clk);
    check(done == 1'b0 && found == 1'b0 && cur_key == 24'h0, "R1 reset again", 32'(cur_key), 0);
    finish_run();
  end
endmodule